// File: doc/BRIEF.md
# Dual-Lane NOR Flash Command Interface

This block is a synthesizable behavioural model of a parallel NOR flash command interface, made of two identical 16-bit devices placed side by side on a 32-bit data bus. Software talks to it by writing command bytes, usually copied into both 16-bit halves, and reading back array contents, status or identification words. Each half of the bus goes to its own lane. A lane decodes its own commands, keeps its own status and read mode, and runs word programs, block erases and block lock changes on a small internal array.

A lane is busy for a set number of cycles after each program or erase, and shows this through its ready status bit. The combined `ready` output is high only when every lane is ready. Protection errors are reported in sticky status bits that stay set until a clear command. Programming can only turn ones into zeros, as in a real NOR cell.

Top module: `nflash_dual`

## Requirements
- R1: After reset every lane is in read-array mode, every array word reads 0xFFFF, every block is locked, `ready` is 1 and the lane status reads 0x0080.
- R2: Each 16-bit half of `wdata` is decoded only by its own lane, using bits 7:0 of that half as the command byte. `ready` is 1 only when status bit 7 is set in every lane.
- R3: Command 0xFF selects read-array mode. Command 0x70 selects read-status mode, in which the lane returns its status in bits 7:0 and zero in bits 15:8.
- R4: Command 0x50 clears status bits 5 (erase error), 4 (program error) and 1 (block locked), and leaves the read mode unchanged.
- R5: Command 0x40 followed by a data write to an unlocked block replaces the addressed word with (old AND data). Status bit 7 then stays low for PROG_CYC cycles after the data write, and the lane stays in read-status mode until 0xFF is written.
- R6: A program data write to a locked block sets status bits 4 and 1, starts no busy period and leaves the array unchanged. Both bits persist until 0x50.
- R7: Command 0x60 followed by data 0x01 locks the addressed block, and 0x60 followed by 0xD0 unlocks it. Any other second byte changes no lock bit. The lane reads status afterwards.
- R8: Command 0x90 selects identifier mode. Word offset 0 within a block returns MFR_ID, offset 1 returns DEV_ID, offset 2 returns that block's lock bit in bit 0, and every other offset returns 0.
- R9: Command 0x98 selects query mode, which reads 0. Command 0xE8 is recognised and only selects read-status mode. Any other unlisted byte in the first cycle is ignored and keeps the current mode.
- R10: Command 0x20 followed by 0xD0 on an unlocked block sets every word of that block to 0xFFFF, with status bit 7 low for ERASE_CYC cycles. On a locked block it sets bits 5 and 1 and changes nothing else. Any second byte other than 0xD0 erases nothing.
- R11: A write to a lane while its status bit 7 is low is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| addr | input | AW (6) | Word address; upper BW bits select the block |
| wdata | input | LANES*LANE_W (32) | Write data, one 16-bit half per lane |
| rdata | output | LANES*LANE_W (32) | Read data per lane, selected by that lane's mode |
| ready | output | 1 | High when every lane is ready |

## Verification
The in-line assertions check on every cycle that an accepted program on an unlocked block drops the ready bit, that a program on a locked block raises both error flags, and that the clear command empties the error bits. They also check that a stored word only ever loses ones and that a write during a busy period leaves the lane's mode and pending state untouched. Only the bench scenarios can show the exact length of the busy windows, the independence of the two lanes when their halves carry different commands, the identifier and query contents, and the erase and lock sequences that observably leave the array or lock bits alone.

// File: rtl/nflash_pkg.sv
// Shared command codes, status bit positions and state types for the
// dual-lane NOR flash command interface.
package nflash_pkg;

    localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_READ_STATUS = 8'h70;
    localparam logic [7:0] OP_CLEAR       = 8'h50;
    localparam logic [7:0] OP_PROGRAM     = 8'h40;
    localparam logic [7:0] OP_LOCK_SETUP  = 8'h60;
    localparam logic [7:0] OP_LOCK        = 8'h01;
    localparam logic [7:0] OP_CONFIRM     = 8'hD0;
    localparam logic [7:0] OP_IDENT       = 8'h90;
    localparam logic [7:0] OP_QUERY       = 8'h98;
    localparam logic [7:0] OP_BUF_WRITE   = 8'hE8;
    localparam logic [7:0] OP_ERASE       = 8'h20;

    localparam int ST_READY     = 7;
    localparam int ST_ERASE_ERR = 5;
    localparam int ST_PROG_ERR  = 4;
    localparam int ST_LOCKED    = 1;

    typedef enum logic [1:0] {
        RD_ARRAY,
        RD_STATUS,
        RD_IDENT,
        RD_QUERY
    } rd_mode_t;

    typedef enum logic [1:0] {
        PEND_NONE,
        PEND_PROG,
        PEND_LOCK,
        PEND_ERASE
    } pend_t;

endpackage

// File: rtl/nflash_store.sv
// Per-lane storage: word array plus one lock bit per block.
// Assumes a single shared address for read and update; program ANDs the
// data into the word, erase fills a whole block with ones, lock_we writes
// the lock bit of the addressed block. Reset fills ones and locks all blocks.
module nflash_store #(
    parameter int W  = 16,
    parameter int AW = 6,
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          prog_en,
    input  logic [W-1:0]  prog_data,
    input  logic          erase_en,
    input  logic          lock_we,
    input  logic          lock_val,
    output logic [W-1:0]  rd_word,
    output logic          rd_locked
);
    localparam int DEPTH     = 1 << AW;
    localparam int OW        = AW - BW;
    localparam int NBLK      = 1 << BW;
    localparam int BLK_WORDS = 1 << OW;

    logic [W-1:0]    mem [DEPTH];
    logic [NBLK-1:0] lock_q;
    logic [BW-1:0]   blk;

    assign blk       = addr[AW-1:OW];
    assign rd_word   = mem[addr];
    assign rd_locked = lock_q[blk];

    // Array and lock bit update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
            lock_q <= '1;
        end else begin
            if (prog_en) mem[addr] <= mem[addr] & prog_data;
            if (erase_en) begin
                for (int i = 0; i < BLK_WORDS; i++) mem[{blk, i[OW-1:0]}] <= '1;
            end
            if (lock_we) lock_q[blk] <= lock_val;
        end
    end

    // Capture of the last programmed word for the bit-clearing check
    logic [AW-1:0] chk_addr;
    logic [W-1:0]  chk_old;
    logic [W-1:0]  chk_data;
    logic          chk_v;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_v    <= 1'b0;
            chk_addr <= '0;
            chk_old  <= '0;
            chk_data <= '0;
        end else begin
            chk_v    <= prog_en;
            chk_addr <= addr;
            chk_old  <= mem[addr];
            chk_data <= prog_data;
        end
    end

    AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        chk_v |-> (((mem[chk_addr] & ~chk_old) == '0) && ((mem[chk_addr] & ~chk_data) == '0))); // R5

endmodule

// File: rtl/nflash_lane.sv
// One 16-bit flash lane: command decoder, status register, busy timer and
// read-data mux in front of its own store. Assumes one bus write per cycle
// and at least four words per block (offsets 0..2 carry identifier data).
module nflash_lane
    import nflash_pkg::*;
#(
    parameter int          W         = 16,
    parameter int          AW        = 6,
    parameter int          BW        = 2,
    parameter int          PROG_CYC  = 8,
    parameter int          ERASE_CYC = 20,
    parameter logic [15:0] MFR_ID    = 16'h0089,
    parameter logic [15:0] DEV_ID    = 16'h0018
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic          ready
);
    localparam int OW    = AW - BW;
    localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    rd_mode_t       mode;
    pend_t          pend;
    logic           st_pe, st_ee, st_bl;
    logic [CNT_W-1:0] busy_cnt;
    logic           busy, acc;
    logic [7:0]     op;
    logic [7:0]     stat;
    logic [W-1:0]   arr_word;
    logic           blk_locked;
    logic           prog_en, erase_en, lock_we, lock_val;

    assign op    = wdata[7:0];
    assign busy  = (busy_cnt != '0);
    assign acc   = wr_en && !busy;
    assign ready = !busy;
    assign stat  = {!busy, 1'b0, st_ee, st_pe, 2'b00, st_bl, 1'b0};

    // Store update strobes from the second cycle of each sequence
    always_comb begin
        prog_en  = acc && (pend == PEND_PROG) && !blk_locked;
        erase_en = acc && (pend == PEND_ERASE) && (op == OP_CONFIRM) && !blk_locked;
        lock_we  = acc && (pend == PEND_LOCK) && ((op == OP_LOCK) || (op == OP_CONFIRM));
        lock_val = (op == OP_LOCK);
    end

    // Command decoder, status flags and busy timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= RD_ARRAY;
            pend     <= PEND_NONE;
            st_pe    <= 1'b0;
            st_ee    <= 1'b0;
            st_bl    <= 1'b0;
            busy_cnt <= '0;
        end else begin
            if (busy) busy_cnt <= busy_cnt - 1'b1;
            if (acc) begin
                case (pend)
                    PEND_PROG: begin
                        pend <= PEND_NONE;
                        mode <= RD_STATUS;
                        if (blk_locked) begin
                            st_pe <= 1'b1;
                            st_bl <= 1'b1;
                        end else begin
                            busy_cnt <= CNT_W'(PROG_CYC);
                        end
                    end
                    PEND_LOCK: begin
                        pend <= PEND_NONE;
                        mode <= RD_STATUS;
                    end
                    PEND_ERASE: begin
                        pend <= PEND_NONE;
                        mode <= RD_STATUS;
                        if (op == OP_CONFIRM) begin
                            if (blk_locked) begin
                                st_ee <= 1'b1;
                                st_bl <= 1'b1;
                            end else begin
                                busy_cnt <= CNT_W'(ERASE_CYC);
                            end
                        end
                    end
                    default: begin
                        case (op)
                            OP_READ_ARRAY:  mode <= RD_ARRAY;
                            OP_READ_STATUS: mode <= RD_STATUS;
                            OP_CLEAR: begin
                                st_pe <= 1'b0;
                                st_ee <= 1'b0;
                                st_bl <= 1'b0;
                            end
                            OP_PROGRAM: begin
                                pend <= PEND_PROG;
                                mode <= RD_STATUS;
                            end
                            OP_LOCK_SETUP: begin
                                pend <= PEND_LOCK;
                                mode <= RD_STATUS;
                            end
                            OP_ERASE: begin
                                pend <= PEND_ERASE;
                                mode <= RD_STATUS;
                            end
                            OP_IDENT:     mode <= RD_IDENT;
                            OP_QUERY:     mode <= RD_QUERY;
                            OP_BUF_WRITE: mode <= RD_STATUS;
                            default: ;
                        endcase
                    end
                endcase
            end
        end
    end

    // Read data selection by mode
    always_comb begin
        case (mode)
            RD_ARRAY:  rdata = arr_word;
            RD_STATUS: rdata = W'(stat);
            RD_IDENT: begin
                if (addr[OW-1:0] == OW'(0))      rdata = W'(MFR_ID);
                else if (addr[OW-1:0] == OW'(1)) rdata = W'(DEV_ID);
                else if (addr[OW-1:0] == OW'(2)) rdata = W'(blk_locked);
                else                             rdata = '0;
            end
            default:   rdata = '0;
        endcase
    end

    nflash_store #(
        .W  (W),
        .AW (AW),
        .BW (BW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .prog_en   (prog_en),
        .prog_data (wdata),
        .erase_en  (erase_en),
        .lock_we   (lock_we),
        .lock_val  (lock_val),
        .rd_word   (arr_word),
        .rd_locked (blk_locked)
    );

    AST_PROG_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (pend == PEND_PROG) && !blk_locked) |=> !ready); // R5

    AST_LOCKED_PROG_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (pend == PEND_PROG) && blk_locked) |=> (stat[ST_PROG_ERR] && stat[ST_LOCKED] && ready)); // R6

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (pend == PEND_NONE) && (op == OP_CLEAR)) |=>
        (!stat[ST_ERASE_ERR] && !stat[ST_PROG_ERR] && !stat[ST_LOCKED] && $stable(mode))); // R4

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> ($stable(mode) && $stable(pend))); // R11

endmodule

// File: rtl/nflash_dual.sv
// Top level: LANES identical flash lanes side by side on one data bus.
// Each lane owns one LANE_W slice of wdata/rdata; all share addr and wr_en.
// Combined ready is the AND of the lanes' ready bits.
module nflash_dual #(
    parameter int          LANES     = 2,
    parameter int          LANE_W    = 16,
    parameter int          AW        = 6,
    parameter int          BW        = 2,
    parameter int          PROG_CYC  = 8,
    parameter int          ERASE_CYC = 20,
    parameter logic [15:0] MFR_ID    = 16'h0089,
    parameter logic [15:0] DEV_ID    = 16'h0018
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    ready
);
    logic [LANES-1:0] lane_rdy;

    // One lane per data slice
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        nflash_lane #(
            .W         (LANE_W),
            .AW        (AW),
            .BW        (BW),
            .PROG_CYC  (PROG_CYC),
            .ERASE_CYC (ERASE_CYC),
            .MFR_ID    (MFR_ID),
            .DEV_ID    (DEV_ID)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_en),
            .addr  (addr),
            .wdata (wdata[g*LANE_W +: LANE_W]),
            .rdata (rdata[g*LANE_W +: LANE_W]),
            .ready (lane_rdy[g])
        );
    end

    assign ready = &lane_rdy;

    AST_READY_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (lane_rdy == {LANES{1'b1}})); // R2

endmodule

// File: tb/nflash_dual_bench.sv
// Scoreboard bench: driver tasks queue expected items, a monitor pops and
// compares them shortly after each falling edge.
module nflash_dual_bench;
    localparam int PROG_CYC  = 8;
    localparam int ERASE_CYC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ready;

    typedef struct packed {
        logic [1:0]  kind;   // 0 rdata, 1 ready, 2 supplied value
        logic [31:0] exp;
        logic [31:0] act;
        logic [7:0]  req;
    } item_t;

    item_t q[$];
    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    nflash_dual #(
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_nflash_dual (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .ready (ready)
    );

    // Monitor: compare queued expectations away from the clock edges
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                vectors++;
                case (it.kind)
                    2'd0:    act = rdata;
                    2'd1:    act = {31'b0, ready};
                    default: act = it.act;
                endcase
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL R%0d actual=%h expected=%h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cmd(input logic [5:0] a, input logic [7:0] c);
        bus_wr(a, {8'h00, c, 8'h00, c});
    endtask

    task automatic chk_rd(input logic [5:0] a, input logic [31:0] e, input int r);
        item_t it;
        addr = a;
        it.kind = 2'd0; it.exp = e; it.act = '0; it.req = 8'(r);
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic chk_rdy(input logic e, input int r);
        item_t it;
        it.kind = 2'd1; it.exp = {31'b0, e}; it.act = '0; it.req = 8'(r);
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (ready !== 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic chk_busy(input int e, input int r);
        item_t it;
        int n;
        wait_ready(n);
        it.kind = 2'd2; it.exp = 32'(e); it.act = 32'(n); it.req = 8'(r);
        q.push_back(it);
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    localparam logic [31:0] ST_OK = 32'h0080_0080;

    // Driver: scenario sequence
    initial begin
        logic [31:0] e5;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_rd(6'h00, 32'hFFFF_FFFF, 1);
        chk_rd(6'h2A, 32'hFFFF_FFFF, 1);
        chk_rdy(1'b1, 1);
        cmd(0, 8'h70);
        chk_rd(6'h00, ST_OK, 1);
        cmd(0, 8'h90);
        chk_rd(6'h02, 32'h0001_0001, 1);   // R1 blocks locked
        chk_rd(6'h32, 32'h0001_0001, 1);

        // R6 program on locked block 0
        cmd(5, 8'h40);
        bus_wr(5, 32'h1234_1234);
        chk_rd(6'h05, 32'h0092_0092, 6);
        chk_rdy(1'b1, 6);
        cmd(0, 8'hFF);
        chk_rd(6'h05, 32'hFFFF_FFFF, 6);
        cmd(0, 8'h70);
        chk_rd(6'h00, 32'h0092_0092, 6);   // R6 persists
        // R4 clear keeps status mode
        cmd(0, 8'h50);
        chk_rd(6'h00, ST_OK, 4);

        // R7 unlock block 0
        cmd(0, 8'h60);
        cmd(0, 8'hD0);
        chk_rd(6'h00, ST_OK, 7);
        cmd(0, 8'h90);
        chk_rd(6'h02, 32'h0000_0000, 7);
        chk_rd(6'h12, 32'h0001_0001, 7);

        // R5 program with AND semantics and busy length
        e5 = 32'hFFFF_FFFF;
        cmd(5, 8'h40);
        bus_wr(5, 32'h0F0F_F0F0);
        e5 = e5 & 32'h0F0F_F0F0;
        chk_busy(PROG_CYC, 5);
        chk_rd(6'h05, ST_OK, 5);           // R5 still status mode
        cmd(0, 8'hFF);
        chk_rd(6'h05, e5, 5);
        cmd(5, 8'h40);
        bus_wr(5, 32'h3C3C_3C3C);
        e5 = e5 & 32'h3C3C_3C3C;
        // R11 write during busy ignored (would select array mode)
        cmd(0, 8'hFF);
        wait_ready(n);
        chk_rd(6'h05, ST_OK, 11);
        cmd(0, 8'hFF);
        chk_rd(6'h05, e5, 5);

        // R2 lanes decoded independently
        bus_wr(6, 32'h00FF_0040);
        bus_wr(6, 32'hAAAA_5555);
        chk_rdy(1'b0, 2);
        chk_rd(6'h06, 32'hFFFF_0000, 2);
        wait_ready(n);
        chk_rd(6'h06, 32'hFFFF_0080, 2);
        cmd(0, 8'hFF);
        chk_rd(6'h06, 32'hFFFF_5555, 2);

        // R7 relock block 0, then program refused
        cmd(0, 8'h60);
        cmd(0, 8'h01);
        chk_rd(6'h00, ST_OK, 7);
        cmd(7, 8'h40);
        bus_wr(7, 32'h0000_0000);
        chk_rd(6'h07, 32'h0092_0092, 7);
        cmd(0, 8'h50);
        cmd(0, 8'hFF);
        chk_rd(6'h07, 32'hFFFF_FFFF, 7);

        // R7 unlock block 1, bad second byte keeps it unlocked
        cmd(6'h10, 8'h60);
        cmd(6'h10, 8'hD0);
        cmd(6'h10, 8'h60);
        cmd(6'h10, 8'h33);
        cmd(0, 8'h90);
        chk_rd(6'h12, 32'h0000_0000, 7);

        // R10 erase unlocked block 1
        cmd(6'h13, 8'h40);
        bus_wr(6'h13, 32'h0000_0000);
        wait_ready(n);
        cmd(0, 8'hFF);
        chk_rd(6'h13, 32'h0000_0000, 5);
        cmd(6'h10, 8'h20);
        cmd(6'h10, 8'hD0);
        chk_busy(ERASE_CYC, 10);
        cmd(0, 8'hFF);
        chk_rd(6'h13, 32'hFFFF_FFFF, 10);
        chk_rd(6'h05, e5, 10);
        // R10 erase on locked block 0
        cmd(0, 8'h20);
        cmd(0, 8'hD0);
        chk_rd(6'h00, 32'h00A2_00A2, 10);
        chk_rdy(1'b1, 10);
        cmd(0, 8'hFF);
        chk_rd(6'h05, e5, 10);
        cmd(0, 8'h50);
        // R10 erase with bad confirm
        cmd(6'h13, 8'h40);
        bus_wr(6'h13, 32'h0000_0000);
        wait_ready(n);
        cmd(6'h10, 8'h20);
        cmd(6'h10, 8'h77);
        chk_rd(6'h10, ST_OK, 10);
        cmd(0, 8'hFF);
        chk_rd(6'h13, 32'h0000_0000, 10);

        // R8 identifier words
        cmd(0, 8'h90);
        chk_rd(6'h00, 32'h0089_0089, 8);
        chk_rd(6'h01, 32'h0018_0018, 8);
        chk_rd(6'h03, 32'h0000_0000, 8);
        chk_rd(6'h02, 32'h0001_0001, 8);

        // R9 query, buffered write, unknown code
        cmd(0, 8'h98);
        chk_rd(6'h13, 32'h0000_0000, 9);
        chk_rd(6'h05, 32'h0000_0000, 9);
        cmd(0, 8'hE8);
        chk_rd(6'h05, ST_OK, 9);
        cmd(0, 8'hFF);
        cmd(0, 8'h11);
        chk_rd(6'h05, e5, 9);

        // R3 mode switching
        cmd(0, 8'h70);
        chk_rd(6'h05, ST_OK, 3);
        cmd(0, 8'hFF);
        chk_rd(6'h05, e5, 3);

        @(negedge clk);
        @(negedge clk);
        done = 1;
        report();
    end

endmodule